// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter with Shared Multiply-Accumulate

This block is a fixed-point IIR filter. It is built as a chain of second-order sections, and each section is a direct-form structure that keeps two past inputs and two past outputs. The sections take turns on a single signed multiplier and one wide accumulator, under the control of a small sequencer. A sample arrives on a one-cycle valid strobe. It passes through every active section in order, and each section's rounded and saturated result becomes the input of the next. A one-cycle done strobe then presents the final value.

The gain of a section is multiplied into its three feedforward coefficients before they are written. Each section therefore costs exactly five products. Coefficients and the active section count are written through an address/data port. A synchronous clear empties the filter history but leaves the programming intact. A sample that arrives while the cascade is still working is refused, and a one-cycle overrun pulse reports it.

Top module: `biquad_cascade`

## Requirements
- R1: A section computes acc = b0*x + b1*x1 + b2*x2 - a1*y1 - a2*y2, with 16-bit signed samples, signed Q2.14 coefficients and a 40-bit accumulator. The final section's result appears on `out_data`, which holds its value until the next done strobe.
- R2: The result is rounded by adding 2^13 to the accumulator and then shifting it arithmetically right by 14. A tie therefore rounds toward positive infinity, so an accumulator of -8192 gives 0.
- R3: The rounded value is saturated to the range -32768..32767 before it is stored or passed on.
- R4: Each section holds x1, x2, y1 and y2, all zero after reset. When the section finishes a sample, x2 takes x1, x1 takes the section input, y2 takes y1, and y1 takes the saturated section output.
- R5: The output of section i is the input of section i+1. `out_data` is the output of the last active section.
- R6: `cfg_addr` = {section[2:0], field[2:0]}. Fields 0..4 select b0, b1, b2, a1 and a2 of that section. Field 5 selects the active section count, whatever the section bits are. A count write is accepted only if `cfg_data` lies in 1..8; any other value leaves the count unchanged. Fields 6 and 7 are ignored.
- R7: A sample accepted on a clock edge produces a one-cycle `out_valid` exactly 6*N clock edges later, where N is the active count. `busy` is high from the accepting edge until that pulse, and low during the pulse.
- R8: If `in_valid` is high while `busy` is high, `overrun` pulses for one cycle and the sample is dropped: no section state changes because of it.
- R9: `clr` zeros the state of every section and aborts any sample in progress, so no `out_valid` follows. Coefficients, the count and `out_data` keep their values.
- R10: After reset, all coefficients are zero, the active count is 1, and `busy`, `out_valid`, `overrun` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all section state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | {section, field} write address |
| cfg_data | input | 16 | Coefficient (Q2.14) or section count |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Signed input sample |
| busy | output | 1 | Cascade is processing a sample |
| out_valid | output | 1 | One-cycle done strobe |
| out_data | output | 16 | Signed filtered output, held between strobes |
| overrun | output | 1 | One-cycle pulse when a sample was dropped |

## Verification
The assertions check the following on every cycle. The done strobe lasts one cycle, comes exactly six busy cycles per active section after acceptance, and is never raised while busy. Overrun pulses exactly when a strobe meets a busy cascade. A clear leaves the cascade idle. The section count stays within 1..8. The numeric behaviour can only be shown by the bench's scenarios: the rounding tie direction, saturation at both rails, the history shifts in each section, the chaining order, the rejected count writes, and the proof that a dropped or cleared sample leaves no trace in later outputs.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
  localparam int TAP_W    = 3;
  localparam int NUM_TAPS = 5;
  localparam logic [TAP_W-1:0] TAP_B0    = 3'd0;
  localparam logic [TAP_W-1:0] TAP_B1    = 3'd1;
  localparam logic [TAP_W-1:0] TAP_B2    = 3'd2;
  localparam logic [TAP_W-1:0] TAP_A1    = 3'd3;
  localparam logic [TAP_W-1:0] TAP_A2    = 3'd4;
  localparam logic [TAP_W-1:0] TAP_COUNT = 3'd5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_MAC  = 2'd1,
    SEQ_WB   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/biquad_coef_store.sv
module biquad_coef_store
  import biquad_pkg::*;
#(
  parameter int MAX_SEC = 8,
  parameter int COEF_W  = 16,
  parameter int SEC_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEC_W-1:0]  wr_sec,
  input  logic [TAP_W-1:0]  wr_tap,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [SEC_W-1:0]  rd_sec,
  input  logic [TAP_W-1:0]  rd_tap,
  output logic [COEF_W-1:0] rd_coef,
  output logic [CNT_W-1:0]  active_cnt
);
  localparam int FLAT_W = MAX_SEC * NUM_TAPS * COEF_W;

  logic [FLAT_W-1:0] coef_flat;
  logic              cnt_hit;

  for (genvar s = 0; s < MAX_SEC; s++) begin : g_sec
    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      logic              hit;
      logic [COEF_W-1:0] coef_q;
      assign hit = wr_en && (wr_sec == SEC_W'(s)) && (wr_tap == TAP_W'(t));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   coef_q <= '0;
        else if (hit) coef_q <= wr_data;
      end
      assign coef_flat[(s*NUM_TAPS+t)*COEF_W +: COEF_W] = coef_q;
    end
  end

  always_comb begin
    rd_coef = '0;
    if (rd_tap < TAP_W'(NUM_TAPS))
      rd_coef = coef_flat[(int'(rd_sec)*NUM_TAPS + int'(rd_tap))*COEF_W +: COEF_W];
  end

  // section count: only a legal value is taken
  assign cnt_hit = wr_en && (wr_tap == TAP_COUNT) &&
                   (wr_data >= COEF_W'(1)) && (wr_data <= COEF_W'(MAX_SEC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_cnt <= CNT_W'(1);
    else if (cnt_hit) active_cnt <= wr_data[CNT_W-1:0];
  end
endmodule

// File: rtl/biquad_state_store.sv
module biquad_state_store #(
  parameter int MAX_SEC = 8,
  parameter int DATA_W  = 16,
  parameter int SEC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              upd,
  input  logic [SEC_W-1:0]  sec,
  input  logic [DATA_W-1:0] x_new,
  input  logic [DATA_W-1:0] y_new,
  output logic [DATA_W-1:0] x1,
  output logic [DATA_W-1:0] x2,
  output logic [DATA_W-1:0] y1,
  output logic [DATA_W-1:0] y2
);
  localparam int FLAT_W = MAX_SEC * DATA_W;

  logic [FLAT_W-1:0] x1_flat, x2_flat, y1_flat, y2_flat;

  for (genvar s = 0; s < MAX_SEC; s++) begin : g_sec
    logic [DATA_W-1:0] x1_q, x2_q, y1_q, y2_q;
    logic              en;
    assign en = upd && (sec == SEC_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
      end else if (clr) begin
        x1_q <= '0; x2_q <= '0; y1_q <= '0; y2_q <= '0;
      end else if (en) begin
        x2_q <= x1_q;
        x1_q <= x_new;
        y2_q <= y1_q;
        y1_q <= y_new;
      end
    end
    assign x1_flat[s*DATA_W +: DATA_W] = x1_q;
    assign x2_flat[s*DATA_W +: DATA_W] = x2_q;
    assign y1_flat[s*DATA_W +: DATA_W] = y1_q;
    assign y2_flat[s*DATA_W +: DATA_W] = y2_q;
  end

  assign x1 = x1_flat[int'(sec)*DATA_W +: DATA_W];
  assign x2 = x2_flat[int'(sec)*DATA_W +: DATA_W];
  assign y1 = y1_flat[int'(sec)*DATA_W +: DATA_W];
  assign y2 = y2_flat[int'(sec)*DATA_W +: DATA_W];
endmodule

// File: rtl/biquad_mac.sv
module biquad_mac #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int ACC_W  = 40,
  parameter int FRAC   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_clr,
  input  logic              acc_en,
  input  logic              acc_sub,
  input  logic [DATA_W-1:0] opnd,
  input  logic [COEF_W-1:0] coef,
  output logic [DATA_W-1:0] y_sat
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] YMAX =
    {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] YMIN =
    {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext, acc_d, acc_q, rnd, shf;

  assign prod     = $signed(opnd) * $signed(coef);
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_comb begin
    acc_d = acc_q;
    if (acc_clr)     acc_d = '0;
    else if (acc_en) acc_d = acc_sub ? (acc_q - prod_ext) : (acc_q + prod_ext);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  // round half up, then clamp to the sample range
  assign rnd = acc_q + HALF;
  assign shf = rnd >>> FRAC;

  always_comb begin
    if (shf > YMAX)      y_sat = YMAX[DATA_W-1:0];
    else if (shf < YMIN) y_sat = YMIN[DATA_W-1:0];
    else                 y_sat = shf[DATA_W-1:0];
  end
endmodule

// File: rtl/biquad_seq.sv
module biquad_seq
  import biquad_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEC_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CNT_W-1:0]  active_cnt,
  input  logic [DATA_W-1:0] y_sat,
  output logic              busy,
  output logic              mac_clr,
  output logic              mac_en,
  output logic              mac_sub,
  output logic              st_upd,
  output logic [SEC_W-1:0]  sec,
  output logic [TAP_W-1:0]  tap,
  output logic [DATA_W-1:0] cur_x,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);
  seq_state_e        state_q, state_d;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic [DATA_W-1:0] curx_q, curx_d, outd_q, outd_d;
  logic              outv_q, outv_d, ovr_q, ovr_d;
  logic              last_sec;

  assign last_sec = (CNT_W'(sec_q) + CNT_W'(1)) == active_cnt;

  always_comb begin
    state_d = state_q;
    sec_d   = sec_q;
    tap_d   = tap_q;
    curx_d  = curx_q;
    outd_d  = outd_q;
    outv_d  = 1'b0;
    ovr_d   = 1'b0;
    mac_clr = 1'b0;
    mac_en  = 1'b0;
    st_upd  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (in_valid) begin
          curx_d  = in_data;
          sec_d   = '0;
          tap_d   = TAP_B0;
          mac_clr = 1'b1;
          state_d = SEQ_MAC;
        end
      end
      SEQ_MAC: begin
        mac_en = 1'b1;
        if (tap_q == TAP_A2) state_d = SEQ_WB;
        else                 tap_d   = tap_q + 1'b1;
      end
      SEQ_WB: begin
        st_upd = 1'b1;
        curx_d = y_sat;
        if (last_sec) begin
          outv_d  = 1'b1;
          outd_d  = y_sat;
          state_d = SEQ_IDLE;
        end else begin
          sec_d   = sec_q + 1'b1;
          tap_d   = TAP_B0;
          mac_clr = 1'b1;
          state_d = SEQ_MAC;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
    if ((state_q != SEQ_IDLE) && in_valid) ovr_d = 1'b1;
    if (clr) begin
      state_d = SEQ_IDLE;
      mac_en  = 1'b0;
      mac_clr = 1'b1;
      st_upd  = 1'b0;
      outv_d  = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      sec_q   <= '0;
      tap_q   <= '0;
      curx_q  <= '0;
      outd_q  <= '0;
      outv_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sec_q   <= sec_d;
      tap_q   <= tap_d;
      curx_q  <= curx_d;
      outd_q  <= outd_d;
      outv_q  <= outv_d;
      ovr_q   <= ovr_d;
    end
  end

  assign busy      = (state_q != SEQ_IDLE);
  assign mac_sub   = (tap_q == TAP_A1) || (tap_q == TAP_A2);
  assign sec       = sec_q;
  assign tap       = tap_q;
  assign cur_x     = curx_q;
  assign out_valid = outv_q;
  assign out_data  = outd_q;
  assign overrun   = ovr_q;
endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int MAX_SEC = 8,
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int FRAC    = 14,
  parameter int ACC_W   = 40,
  localparam int SEC_W  = (MAX_SEC > 1) ? $clog2(MAX_SEC) : 1,
  localparam int CNT_W  = $clog2(MAX_SEC + 1),
  localparam int ADDR_W = SEC_W + TAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [COEF_W-1:0] cfg_data,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              busy,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              overrun
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic [CNT_W-1:0]  active_cnt;
  logic [COEF_W-1:0] coef;
  logic [DATA_W-1:0] x1, x2, y1, y2, cur_x, y_sat;
  logic [DATA_W-1:0] opnd;
  logic [SEC_W-1:0]  sec;
  logic [TAP_W-1:0]  tap;
  logic              mac_clr, mac_en, mac_sub, st_upd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  biquad_coef_store #(
    .MAX_SEC(MAX_SEC), .COEF_W(COEF_W), .SEC_W(SEC_W), .CNT_W(CNT_W)
  ) u_coef (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en     (cfg_we),
    .wr_sec    (cfg_addr[ADDR_W-1:TAP_W]),
    .wr_tap    (cfg_addr[TAP_W-1:0]),
    .wr_data   (cfg_data),
    .rd_sec    (sec),
    .rd_tap    (tap),
    .rd_coef   (coef),
    .active_cnt(active_cnt)
  );

  biquad_state_store #(
    .MAX_SEC(MAX_SEC), .DATA_W(DATA_W), .SEC_W(SEC_W)
  ) u_state (
    .clk  (clk),
    .rst_n(rst_core_n),
    .clr  (clr),
    .upd  (st_upd),
    .sec  (sec),
    .x_new(cur_x),
    .y_new(y_sat),
    .x1   (x1),
    .x2   (x2),
    .y1   (y1),
    .y2   (y2)
  );

  always_comb begin
    case (tap)
      TAP_B0:  opnd = cur_x;
      TAP_B1:  opnd = x1;
      TAP_B2:  opnd = x2;
      TAP_A1:  opnd = y1;
      TAP_A2:  opnd = y2;
      default: opnd = '0;
    endcase
  end

  biquad_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .FRAC(FRAC)
  ) u_mac (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .acc_clr(mac_clr),
    .acc_en (mac_en),
    .acc_sub(mac_sub),
    .opnd   (opnd),
    .coef   (coef),
    .y_sat  (y_sat)
  );

  biquad_seq #(
    .DATA_W(DATA_W), .SEC_W(SEC_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .active_cnt(active_cnt),
    .y_sat     (y_sat),
    .busy      (busy),
    .mac_clr   (mac_clr),
    .mac_en    (mac_en),
    .mac_sub   (mac_sub),
    .st_upd    (st_upd),
    .sec       (sec),
    .tap       (tap),
    .cur_x     (cur_x),
    .out_valid (out_valid),
    .out_data  (out_data),
    .overrun   (overrun)
  );
endmodule

// File: rtl/biquad_cascade_chk.sv
module biquad_cascade_chk #(
  parameter int MAX_SEC = 8,
  parameter int CNT_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             busy,
  input logic             out_valid,
  input logic             overrun,
  input logic [CNT_W-1:0] active_cnt
);
  logic [15:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 16'd1;
    else           busy_len <= '0;
  end

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid) else $error("done strobe longer than one cycle");

  // R7
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (busy_len == 16'(active_cnt) * 16'd6))
    else $error("done strobe at wrong distance from acceptance");

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy) else $error("busy high during done strobe");

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy && in_valid && !clr)) else $error("overrun without cause");

  // R8
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !clr) |=> overrun) else $error("missed overrun");

  // R9
  clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !out_valid)) else $error("cascade active after clear");

  // R6
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_cnt >= CNT_W'(1)) && (active_cnt <= CNT_W'(MAX_SEC)))
    else $error("section count out of range");
endmodule

bind biquad_cascade biquad_cascade_chk #(
  .MAX_SEC(MAX_SEC), .CNT_W(CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .busy      (busy),
  .out_valid (out_valid),
  .overrun   (overrun),
  .active_cnt(active_cnt)
);

// File: tb/biquad_cascade_tb.sv
module biquad_cascade_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_SEC    = 8;
  localparam int ADDR_W     = 6;
  localparam int WATCHDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              clr = 1'b0;
  logic              cfg_we = 1'b0;
  logic [ADDR_W-1:0] cfg_addr = '0;
  logic [15:0]       cfg_data = '0;
  logic              in_valid = 1'b0;
  logic [15:0]       in_data = '0;
  logic              busy, out_valid, overrun;
  logic [15:0]       out_data;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  armed = 1'b0;
  bit  finished = 1'b0;
  int  cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biquad_cascade u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_data(in_data), .busy(busy),
    .out_valid(out_valid), .out_data(out_data), .overrun(overrun)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint m_coef [MAX_SEC][5];
  longint m_x1 [MAX_SEC], m_x2 [MAX_SEC], m_y1 [MAX_SEC], m_y2 [MAX_SEC];
  int     m_cnt;
  int     m_rem;
  longint m_pend, e_data;
  bit     e_valid, e_ovr;

  function automatic longint sat16(input longint v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint model_sample(input longint xin);
    longint x = xin;
    for (int s = 0; s < m_cnt; s++) begin
      longint acc, y;
      acc = m_coef[s][0]*x + m_coef[s][1]*m_x1[s] + m_coef[s][2]*m_x2[s]
          - m_coef[s][3]*m_y1[s] - m_coef[s][4]*m_y2[s];
      y = sat16((acc + 8192) >>> 14);
      m_x2[s] = m_x1[s]; m_x1[s] = x;
      m_y2[s] = m_y1[s]; m_y1[s] = y;
      x = y;
    end
    return x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < MAX_SEC; s++) begin
        for (int t = 0; t < 5; t++) m_coef[s][t] = 0;
        m_x1[s] = 0; m_x2[s] = 0; m_y1[s] = 0; m_y2[s] = 0;
      end
      m_cnt = 1; m_rem = 0; m_pend = 0; e_data = 0; e_valid = 0; e_ovr = 0;
    end else begin
      e_valid = 0;
      e_ovr   = 0;
      if (cfg_we) begin
        int sec, tap;
        sec = int'(cfg_addr >> 3);
        tap = int'(cfg_addr[2:0]);
        if (tap < 5) m_coef[sec][tap] = longint'($signed(cfg_data));
        else if (tap == 5 && cfg_data >= 1 && cfg_data <= MAX_SEC) m_cnt = int'(cfg_data);
      end
      if (clr) begin
        for (int s = 0; s < MAX_SEC; s++) begin
          m_x1[s] = 0; m_x2[s] = 0; m_y1[s] = 0; m_y2[s] = 0;
        end
        m_rem = 0;
      end else if (m_rem > 0) begin
        if (in_valid) e_ovr = 1;
        m_rem--;
        if (m_rem == 0) begin
          e_valid = 1;
          e_data  = m_pend;
        end
      end else if (in_valid) begin
        m_pend = model_sample(longint'($signed(in_data)));
        m_rem  = 6 * m_cnt;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (armed && !finished) begin
      check(out_valid === e_valid, "R7 out_valid", longint'(out_valid), longint'(e_valid));
      check(busy === (m_rem > 0), "R7 busy", longint'(busy), longint'(m_rem > 0));
      check(overrun === e_ovr, "R8 overrun", longint'(overrun), longint'(e_ovr));
      check(longint'($signed(out_data)) == e_data, "R1 out_data",
            longint'($signed(out_data)), e_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers (enter and leave just after a negedge) ----------------
  task automatic wr(input int sec, input int tap, input int val);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(sec*8 + tap); cfg_data = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_sec(input int sec, input int b0, input int b1, input int b2,
                         input int a1, input int a2);
    wr(sec, 0, b0); wr(sec, 1, b1); wr(sec, 2, b2); wr(sec, 3, a1); wr(sec, 4, a2);
  endtask

  task automatic pulse_clr();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run(input int x, output int y, output int lat);
    in_valid = 1'b1; in_data = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    y = int'($signed(out_data));
  endtask

  initial begin
    int y, lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    armed = 1'b1;

    // R10 reset state
    check(out_data == 16'd0 && !busy && !out_valid && !overrun, "R10 reset outputs",
          longint'({busy, out_valid, overrun, out_data != 16'd0}), 0);
    run(1000, y, lat);
    check(y == 0, "R10 zero coefficients", y, 0);
    check(lat == 6, "R10 count is one", lat, 6);

    // R1 pass-through with b0 = 1.0
    set_sec(0, 16384, 0, 0, 0, 0);
    run(-32768, y, lat); check(y == -32768, "R1 pass negative rail", y, -32768);
    run(1234, y, lat);   check(y == 1234, "R1 pass value", y, 1234);

    // R2 rounding with b0 = 1 LSB
    set_sec(0, 1, 0, 0, 0, 0);
    run(8192, y, lat);  check(y == 1, "R2 tie up", y, 1);
    run(8191, y, lat);  check(y == 0, "R2 below half", y, 0);
    run(-8192, y, lat); check(y == 0, "R2 negative tie toward +inf", y, 0);
    run(-8193, y, lat); check(y == -1, "R2 negative past half", y, -1);

    // R3 saturation with b0 just under 2.0
    set_sec(0, 32767, 0, 0, 0, 0);
    run(32767, y, lat);  check(y == 32767, "R3 positive clamp", y, 32767);
    run(-32768, y, lat); check(y == -32768, "R3 negative clamp", y, -32768);

    // R4 history: b2 path, a1 path, a2 path
    set_sec(0, 0, 0, 16384, 0, 0);
    pulse_clr();
    run(11, y, lat); check(y == 0, "R4 x2 empty", y, 0);
    run(22, y, lat); check(y == 0, "R4 x2 empty", y, 0);
    run(33, y, lat); check(y == 11, "R4 x2 shift", y, 11);
    set_sec(0, 16384, 0, 0, -8192, 0);
    pulse_clr();
    run(1000, y, lat); check(y == 1000, "R4 a1 step", y, 1000);
    run(0, y, lat);    check(y == 500, "R4 a1 decay", y, 500);
    run(0, y, lat);    check(y == 250, "R4 a1 decay", y, 250);
    set_sec(0, 16384, 0, 0, 0, -16384);
    pulse_clr();
    run(100, y, lat); check(y == 100, "R4 a2 impulse", y, 100);
    run(0, y, lat);   check(y == 0, "R4 a2 gap", y, 0);
    run(0, y, lat);   check(y == 100, "R4 a2 echo", y, 100);

    // R5 chaining: section 0 unity, section 1 half
    set_sec(0, 16384, 0, 0, 0, 0);
    set_sec(1, 8192, 0, 0, 0, 0);
    wr(0, 5, 2);
    run(1000, y, lat);
    check(y == 500, "R5 two-section chain", y, 500);
    check(lat == 12, "R7 latency two sections", lat, 12);

    // R6 count register legality
    wr(0, 5, 0);
    run(10, y, lat); check(lat == 12, "R6 zero count ignored", lat, 12);
    wr(0, 5, 9);
    run(10, y, lat); check(lat == 12, "R6 oversize count ignored", lat, 12);
    wr(0, 6, 1);
    run(10, y, lat); check(lat == 12, "R6 field six ignored", lat, 12);
    wr(5, 5, 3);
    run(10, y, lat); check(lat == 18, "R6 count with any section bits", lat, 18);
    wr(0, 5, 1);

    // R8 overrun drops the sample: y = x + x1
    set_sec(0, 16384, 16384, 0, 0, 0);
    pulse_clr();
    run(10, y, lat); check(y == 10, "R8 setup", y, 10);
    in_valid = 1'b1; in_data = 16'd20;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    in_valid = 1'b1; in_data = 16'd999;
    @(negedge clk);
    in_valid = 1'b0;
    check(overrun == 1'b1, "R8 overrun pulse", longint'(overrun), 1);
    while (!out_valid) @(negedge clk);
    check($signed(out_data) == 30, "R8 in-flight result", longint'($signed(out_data)), 30);
    run(0, y, lat); check(y == 20, "R8 dropped sample left no state", y, 20);

    // R9 clear: history gone, coefficients kept
    run(50, y, lat);
    pulse_clr();
    run(7, y, lat); check(y == 7, "R9 history cleared", y, 7);
    in_valid = 1'b1; in_data = 16'd5;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    pulse_clr();
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
        if (out_valid || busy) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen, "R9 abort in flight", longint'(seen), 0);
    end
    check($signed(out_data) == 7, "R9 out_data kept", longint'($signed(out_data)), 7);
    run(7, y, lat); check(y == 7, "R9 state zero after abort", y, 7);
    run(3, y, lat); check(y == 10, "R9 coefficients kept", y, 10);

    // random three-section cascade, model compared every cycle
    for (int s = 0; s < 3; s++)
      set_sec(s, int'($urandom_range(16383)) - 8192, int'($urandom_range(16383)) - 8192,
              int'($urandom_range(16383)) - 8192, int'($urandom_range(8191)) - 4096,
              int'($urandom_range(8191)) - 4096);
    wr(0, 5, 3);
    for (int i = 0; i < 150; i++) begin
      run(int'($urandom_range(65535)) - 32768, y, lat);
      if (i == 0) check(lat == 18, "R7 latency three sections", lat, 18);
    end

    // back-to-back strobes: most are overruns
    in_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      in_data = 16'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (40) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule